// File: doc/BRIEF.md
# Table-Driven Decision Feedback Equalizer Core

This block is the decision-feedback half of an equalizer for real-valued binary (±1) symbols. Each sample it accepts is the output of a feed-forward filter computed elsewhere. From that sample the block subtracts an estimate of the trailing intersymbol interference. It then slices the result to a hard decision and returns both the decision and the soft equalized value. The feedback estimate involves no multipliers. It is the sum of two small tables. Each table is indexed by one group of past decisions. The first group holds the most recent decisions and the second group holds the older ones.

A table holds only half of the sums its group can produce. The oldest decision in a group picks the sign. When that decision is -1, the remaining decisions are complemented to form the index and the stored word is negated with XOR-and-increment logic. The feed-forward sample is added after the table outputs, so table contents depend only on the feedback coefficients. Software or an adaptation engine fills the tables through a plain write port while no samples are flowing.

Samples enter on a valid/ready stream and results leave on another. A result is registered and appears one cycle after its sample is accepted. An output that has not been taken holds its value and blocks the input (`s_ready` low) until `m_ready` is seen, so the decision history only advances on an accepted sample. A table write also forces `s_ready` low for that cycle.

Top module: `dfe_lut_fb`

## Requirements
- R1: After reset `m_valid` is 0, `s_ready` is 1, every table word is 0 and all past decisions read as +1, so the first sample's feedback uses table index 0 with positive sign in both stages.
- R2: Decision encoding is bit 0 = +1 and bit 1 = -1. The first stage covers feedback taps b1 (newest decision) and b2. Its word at address a holds b2 + (a[0] ? -b1 : b1).
- R3: The second stage covers taps b3 and b4. Its word at address a holds b4 + (a[0] ? -b3 : b3). `tbl_stage` = 0 selects the first stage and 1 selects the second.
- R4: When the oldest decision of a stage's group is -1, that stage contributes the negated word at the complemented index. Every sign pattern therefore yields the full sum of b_k·d_k over the group.
- R5: `m_soft` = sample - (stage1 + stage2), carried in DATA_W+3 signed bits with no saturation or wrap, for any table contents and sample.
- R6: `m_decision` is 0 (+1) when `m_soft` ≥ 0, including exactly zero, and 1 (-1) when `m_soft` is negative.
- R7: The decision history shifts only when a sample is accepted: the new decision becomes the newest and the oldest is dropped. Idle cycles leave it unchanged.
- R8: A sample accepted at a clock edge yields `m_valid` = 1 with its result from that edge on.
- R9: While `m_valid` = 1 and `m_ready` = 0, `m_soft` and `m_decision` hold and `s_ready` is 0.
- R10: While `tbl_we` = 1, `s_ready` is 0, no sample is accepted, and the addressed word of the selected stage is written at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted when high with s_valid |
| s_sample | input | DATA_W | Feed-forward filter output, signed |
| m_valid | output | 1 | Result present |
| m_ready | input | 1 | Result taken when high with m_valid |
| m_decision | output | 1 | Hard decision, 0 = +1, 1 = -1 |
| m_soft | output | DATA_W+3 | Equalized soft value, signed |
| tbl_we | input | 1 | Table write strobe |
| tbl_stage | input | 1 | Table select, 0 = first stage, 1 = second stage |
| tbl_addr | input | max(S1_TAPS,NTAP-S1_TAPS)-1 | Word address within the selected table |
| tbl_data | input | DATA_W | Signed word to store |

## Verification
The properties assume `tbl_we` is never raised while a result is waiting with `m_ready` low. A write in that state would not harm the design, but the bench keeps writes to drained periods. They also assume `m_ready` behaves as a consumer that may stall at any time. The stimulus writes tables only after one idle cycle with `m_ready` high. It holds `s_valid` steady while stalled and uses coefficient sets whose table words fit in DATA_W bits. The extreme set pushes the soft value toward both ends of its range.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  // Hard decision encoding used across the block
  typedef enum logic {
    DEC_POS = 1'b0,
    DEC_NEG = 1'b1
  } dec_t;

  // Table select on the write port
  typedef enum logic {
    STG_NEAR = 1'b0,
    STG_FAR  = 1'b1
  } stage_t;
endpackage

// File: rtl/dfe_lut_stage.sv
// One half-size feedback table with sign recovery on its output.
module dfe_lut_stage #(
  parameter int TAPS   = 2,
  parameter int DATA_W = 16,
  localparam int IW    = TAPS - 1,
  localparam int DEPTH = 1 << IW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            waddr,
  input  logic signed [DATA_W-1:0] wdata,
  input  logic [TAPS-1:0]          grp,      // bit 0 newest decision of the group
  output logic signed [DATA_W:0]   contrib
);
  logic signed [DATA_W-1:0] mem [DEPTH];
  logic                     flip;
  logic [IW-1:0]            ridx;
  logic signed [DATA_W:0]   word_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // oldest decision of the group selects the sign
  assign flip   = grp[TAPS-1];
  assign ridx   = grp[IW-1:0] ^ {IW{flip}};
  assign word_x = {mem[ridx][DATA_W-1], mem[ridx]};
  // conditional two's complement: invert then add the flag
  assign contrib = ({(DATA_W+1){flip}} ^ word_x) + {{DATA_W{1'b0}}, flip};
endmodule

// File: rtl/dfe_dec_hist.sv
// Shift register of past hard decisions; bit 0 is the newest.
module dfe_dec_hist #(
  parameter int NTAP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            dec_in,
  output logic [NTAP-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)   hist <= {NTAP{dfe_pkg::DEC_POS}};
    else if (adv) hist <= {hist[NTAP-2:0], dec_in};
  end
endmodule

// File: rtl/dfe_lut_fb.sv
module dfe_lut_fb #(
  parameter int DATA_W  = 16,
  parameter int NTAP    = 4,
  parameter int S1_TAPS = 2,
  localparam int S2_TAPS = NTAP - S1_TAPS,
  localparam int IW1     = S1_TAPS - 1,
  localparam int IW2     = S2_TAPS - 1,
  localparam int AW      = (IW1 > IW2) ? IW1 : IW2,
  localparam int SOFT_W  = DATA_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [DATA_W-1:0] s_sample,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     m_decision,
  output logic signed [SOFT_W-1:0] m_soft,
  input  logic                     tbl_we,
  input  logic                     tbl_stage,
  input  logic [AW-1:0]            tbl_addr,
  input  logic signed [DATA_W-1:0] tbl_data
);
  import dfe_pkg::*;

  logic [NTAP-1:0]          hist;
  logic signed [DATA_W:0]   c_near, c_far;
  logic signed [DATA_W+1:0] fb_sum;
  logic signed [SOFT_W-1:0] y_now;
  logic                     dec_now;
  logic                     take;

  assign s_ready = !tbl_we && (!m_valid || m_ready);
  assign take    = s_valid && s_ready;

  dfe_lut_stage #(.TAPS(S1_TAPS), .DATA_W(DATA_W)) u_near (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we && (tbl_stage == STG_NEAR)),
    .waddr  (tbl_addr[IW1-1:0]),
    .wdata  (tbl_data),
    .grp    (hist[S1_TAPS-1:0]),
    .contrib(c_near)
  );

  dfe_lut_stage #(.TAPS(S2_TAPS), .DATA_W(DATA_W)) u_far (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we && (tbl_stage == STG_FAR)),
    .waddr  (tbl_addr[IW2-1:0]),
    .wdata  (tbl_data),
    .grp    (hist[NTAP-1:S1_TAPS]),
    .contrib(c_far)
  );

  // feed-forward sample joins after the tables
  assign fb_sum  = SOFT_W'(c_near) + SOFT_W'(c_far);
  assign y_now   = SOFT_W'(s_sample) - SOFT_W'(fb_sum);
  assign dec_now = y_now[SOFT_W-1] ? DEC_NEG : DEC_POS;

  dfe_dec_hist #(.NTAP(NTAP)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take),
    .dec_in(dec_now),
    .hist  (hist)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid    <= 1'b0;
      m_soft     <= '0;
      m_decision <= DEC_POS;
    end else if (take) begin
      m_valid    <= 1'b1;
      m_soft     <= y_now;
      m_decision <= dec_now;
    end else if (m_ready) begin
      m_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/dfe_lut_fb_chk.sv
module dfe_lut_fb_chk #(
  parameter int SOFT_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_decision,
  input logic [SOFT_W-1:0] m_soft,
  input logic              tbl_we
);
  AST_WRITE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> !s_ready); // R10

  AST_STALL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_soft) && $stable(m_decision))); // R9

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R9

  AST_DECISION_FOLLOWS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_decision == m_soft[SOFT_W-1])); // R6

  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid); // R8

  AST_NO_RESULT_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready)); // R8
endmodule

bind dfe_lut_fb dfe_lut_fb_chk #(.SOFT_W(SOFT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_decision(m_decision),
  .m_soft    (m_soft),
  .tbl_we    (tbl_we)
);

// File: tb/test_dfe_lut_fb.sv
module test_dfe_lut_fb;
  localparam int DATA_W = 16;
  localparam int SOFT_W = DATA_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [DATA_W-1:0] s_sample = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic m_decision;
  logic signed [SOFT_W-1:0] m_soft;
  logic tbl_we = 1'b0;
  logic tbl_stage = 1'b0;
  logic [0:0] tbl_addr = '0;
  logic signed [DATA_W-1:0] tbl_data = '0;

  always #5 clk = ~clk;

  dfe_lut_fb i_dfe_lut_fb (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_sample(s_sample),
    .m_valid(m_valid), .m_ready(m_ready), .m_decision(m_decision), .m_soft(m_soft),
    .tbl_we(tbl_we), .tbl_stage(tbl_stage), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  localparam int NVEC = 16;
  localparam logic signed [DATA_W-1:0] VEC [NVEC] = '{
    16'sd4000, -16'sd3500, 16'sd120, -16'sd90, 16'sd7000, 16'sd6500,
    -16'sd8000, 16'sd300, -16'sd250, 16'sd12000, -16'sd11000, 16'sd50,
    16'sd2500, -16'sd2600, -16'sd40, 16'sd900
  };

  int compared = 0;
  int mismatched = 0;
  int b [4];
  bit mh [4];   // model history, index 0 newest, 1 means -1

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_fb();
    int s = 0;
    for (int k = 0; k < 4; k++) s += mh[k] ? -b[k] : b[k];
    return s;
  endfunction

  // fill both tables from the coefficients using the R2/R3 layout
  task automatic load(input int c1, input int c2, input int c3, input int c4, input bit hold_valid);
    b[0] = c1; b[1] = c2; b[2] = c3; b[3] = c4;
    for (int st = 0; st < 2; st++) begin
      for (int a = 0; a < 2; a++) begin
        @(negedge clk);
        s_valid   = hold_valid;
        s_sample  = 16'sd12345;
        tbl_we    = 1'b1;
        tbl_stage = st[0];
        tbl_addr  = a[0:0];
        tbl_data  = (st == 0) ? DATA_W'(c2 + (a != 0 ? -c1 : c1))
                              : DATA_W'(c4 + (a != 0 ? -c3 : c3));
        #1 chk("R10 s_ready during write", int'(s_ready), 0);
      end
    end
    @(negedge clk);
    tbl_we  = 1'b0;
    s_valid = 1'b0;
  endtask

  // send one sample with m_ready high and check its result next cycle
  task automatic send(input int x, input string req);
    int y;
    @(negedge clk);
    s_valid  = 1'b1;
    s_sample = DATA_W'(x);
    y = x - model_fb();
    @(negedge clk);
    s_valid = 1'b0;
    chk({req, " m_valid"}, int'(m_valid), 1);
    chk({req, " m_soft"}, int'(m_soft), y);
    chk({req, " m_decision"}, int'(m_decision), (y < 0) ? 1 : 0);
    for (int k = 3; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = (y < 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int y;
    for (int k = 0; k < 4; k++) mh[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 m_valid after reset", int'(m_valid), 0);
    chk("R1 s_ready after reset", int'(s_ready), 1);

    // R1: zero tables, all +1 history: soft equals the sample
    b = '{0, 0, 0, 0};
    send(-77, "R1 zero tables");
    // rebuild model history: reset value was +1, now one decision shifted in

    // R2 R3 R4 R5 R6 R7: vector table walk
    load(3000, -1200, 700, -500, 1'b0);
    for (int i = 0; i < NVEC; i++) send(int'(VEC[i]), "R4 R5 vector");

    // R6: soft exactly zero slices to +1
    send(model_fb(), "R6 zero soft");

    // R7: idle cycles with changing sample leave history alone
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s_sample = DATA_W'(i * 1111 - 2000);
    end
    send(-1500, "R7 after idle");

    // R9: stall holds result and blocks input
    @(negedge clk);
    m_ready  = 1'b0;
    s_valid  = 1'b1;
    s_sample = 16'sd2222;
    y = 2222 - model_fb();
    @(negedge clk);
    for (int k = 3; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = (y < 0);
    s_sample = -16'sd3333;
    #1 chk("R9 s_ready during stall", int'(s_ready), 0);
    repeat (2) @(negedge clk);
    chk("R9 held m_soft", int'(m_soft), y);
    chk("R9 held m_valid", int'(m_valid), 1);
    m_ready = 1'b1;
    #1 chk("R9 s_ready on release", int'(s_ready), 1);
    y = -3333 - model_fb();
    @(negedge clk);
    s_valid = 1'b0;
    chk("R8 next result m_soft", int'(m_soft), y);
    for (int k = 3; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = (y < 0);
    @(negedge clk);
    chk("R8 m_valid drops when idle", int'(m_valid), 0);

    // R10: writes with s_valid held high accept nothing
    load(16384, -16384, 16383, 16384, 1'b1);
    chk("R10 nothing accepted during writes", int'(m_valid), 0);

    // R2 R3 R4 R5: extreme words, drive every sign pattern
    send(-32768, "R5 extreme low");
    send(32767, "R5 extreme high");
    send(-32768, "R4 extreme mix");
    send(-32768, "R4 extreme mix2");
    send(32767, "R3 extreme far");
    send(0, "R2 extreme near");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule